// File: doc/BRIEF.md
# Multi-Channel Memory Transfer Engine

This block moves data items from a memory-mapped source address to a memory-mapped destination address for up to seven independent channels. Each channel is started by software through a plain register write port and is then paced by its own peripheral request line. A single shared arbiter picks one channel per item. The engine performs one single-beat read and one single-beat write on its bus master port, and then arbitrates again. A high-priority channel can therefore step in between two items of a lower-priority one.

Every channel has its own source and destination element sizes, so a byte stream can be widened into words and a word stream can be narrowed into half-words. Each channel also has its own address-increment choices, a 16-bit item count, an optional circular mode that rewinds addresses and count when the count runs out, and two sticky event flags: half done and all done. The flags drive the interrupt outputs directly and stay set until software clears them.

Data travels right-justified on the bus. Bus bits 7:0 carry a byte, bits 15:0 carry a half-word, and all 32 bits carry a word. The bus size output tells the slave how many of those bits count.

Top module: `mc_dma`

## Requirements
- R1: After reset the bus request, every completion and half flag output, and every register read value are zero.
- R2: Register address is {channel, index}, with index 0 control, 1 count, 2 source, 3 destination, 4 flags. Control bits are [0] enable, [1] circular, [2] source increment, [3] destination increment, [5:4] source size, [7:6] destination size, [9:8] priority. Size codes are 0 byte, 1 half-word, 2 word. Control reads back its low 10 bits. Count reads the remaining items, and source and destination read the current addresses.
- R3: Each item is one read at the current source address with the source size, followed by one write at the current destination address with the destination size. The bus request, address and direction stay stable until bus_ack.
- R4: Among eligible channels the highest priority value wins (3 is highest). On a tie the lowest channel index wins.
- R5: Arbitration repeats after every item, so a higher-priority request that appears mid-run is served before the next item of the running channel.
- R6: After each item an address with increment enabled advances by its element size (1, 2 or 4). An address with increment disabled holds.
- R7: Write data is the read data cut to the source size, then cut to the destination size. Narrow data is zero-extended and wide data keeps its low bits.
- R8: Each item decrements the remaining count. When the count reaches zero, flags bit 0 (complete) is set and a non-circular channel stops.
- R9: Flags bit 1 (half) is set by the item that leaves the remaining count equal to the programmed count shifted right by one.
- R10: In circular mode, reaching zero reloads the programmed count and both start addresses, and the channel keeps running.
- R11: Clearing enable lets the item in flight finish and starts no further item. The flags stay set until a write of 1 to the matching flags bit.
- R12: A channel whose request is low, or whose remaining count is zero, is never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dreq | input | NCH | Per-channel request lines, level sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | clog2(NCH)+3 | Register address {channel, index} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | 1 for write beat, 0 for read beat |
| bus_addr | output | AW | Beat byte address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | DW | Write data, right-justified |
| bus_rdata | input | DW | Read data, right-justified |
| bus_ack | input | 1 | Beat completion from slave |
| irq_tc | output | NCH | Per-channel completion flag |
| irq_ht | output | NCH | Per-channel half flag |

## Verification
The bench runs directed sequences and fixed-seed random setups that mix byte, half-word and word sizes in both directions with each increment setting. Each random setup tells apart truncation from zero-extension and held addresses from stepped ones. Three channels with mixed priorities raised in the same cycle show the order between priority levels and the tie rule. A low-priority run with a high-priority request raised part-way through shows whether arbitration happens per item or per run. An odd count shows whether the half flag rises exactly one item early or late, and a circular run stopped by clearing enable covers rewind, wrap addresses, the stop after the item in flight and flag persistence.

// File: rtl/mc_dma_pkg.sv
package mc_dma_pkg;

   localparam int CTRL_W = 10;

   localparam logic [2:0] IDX_CTRL  = 3'd0;
   localparam logic [2:0] IDX_COUNT = 3'd1;
   localparam logic [2:0] IDX_SRC   = 3'd2;
   localparam logic [2:0] IDX_DST   = 3'd3;
   localparam logic [2:0] IDX_FLAGS = 3'd4;

   typedef struct packed {
      logic [1:0] prio;
      logic [1:0] dsz;
      logic [1:0] ssz;
      logic       dinc;
      logic       sinc;
      logic       circ;
      logic       en;
   } chan_ctrl_t;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_RD   = 2'd1,
      ENG_WR   = 2'd2
   } eng_state_e;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/mc_dma_chan.sv
module mc_dma_chan
   import mc_dma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [2:0]    cfg_idx,
   input  logic [31:0]   cfg_wdata,
   input  logic [2:0]    rd_idx,
   output logic [31:0]   rd_data,
   input  logic          dreq,
   input  logic          item_done,
   output logic          elig,
   output chan_ctrl_t    ctrl,
   output logic [AW-1:0] cur_src,
   output logic [AW-1:0] cur_dst,
   output logic          flag_tc,
   output logic          flag_ht
);

   chan_ctrl_t    ctrl_q;
   logic [CW-1:0] prog_q, rem_q, rem_dec;
   logic [AW-1:0] bsrc_q, bdst_q, csrc_q, cdst_q;
   logic [AW-1:0] src_step, dst_step;
   logic          tc_q, ht_q;
   logic          last_item, half_item;

   assign rem_dec   = rem_q - 1'b1;
   assign last_item = (rem_dec == '0);
   assign half_item = (rem_dec == (prog_q >> 1));
   assign src_step  = ctrl_q.sinc ? AW'(size_bytes(ctrl_q.ssz)) : '0;
   assign dst_step  = ctrl_q.dinc ? AW'(size_bytes(ctrl_q.dsz)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         prog_q <= '0;
         rem_q  <= '0;
         bsrc_q <= '0;
         bdst_q <= '0;
         csrc_q <= '0;
         cdst_q <= '0;
         tc_q   <= 1'b0;
         ht_q   <= 1'b0;
      end else begin
         if (cfg_wr) begin
            case (cfg_idx)
               IDX_CTRL:  ctrl_q <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
               IDX_COUNT: begin
                  prog_q <= cfg_wdata[CW-1:0];
                  rem_q  <= cfg_wdata[CW-1:0];
               end
               IDX_SRC: begin
                  bsrc_q <= cfg_wdata[AW-1:0];
                  csrc_q <= cfg_wdata[AW-1:0];
               end
               IDX_DST: begin
                  bdst_q <= cfg_wdata[AW-1:0];
                  cdst_q <= cfg_wdata[AW-1:0];
               end
               IDX_FLAGS: begin
                  if (cfg_wdata[0]) tc_q <= 1'b0;
                  if (cfg_wdata[1]) ht_q <= 1'b0;
               end
               default: ;
            endcase
         end
         // a finishing item overrides a same-cycle register write
         if (item_done) begin
            if (half_item) ht_q <= 1'b1;
            if (last_item) tc_q <= 1'b1;
            if (last_item && ctrl_q.circ) begin
               rem_q  <= prog_q;
               csrc_q <= bsrc_q;
               cdst_q <= bdst_q;
            end else begin
               rem_q  <= rem_dec;
               csrc_q <= csrc_q + src_step;
               cdst_q <= cdst_q + dst_step;
            end
         end
      end
   end

   assign elig    = ctrl_q.en && dreq && (rem_q != '0);
   assign ctrl    = ctrl_q;
   assign cur_src = csrc_q;
   assign cur_dst = cdst_q;
   assign flag_tc = tc_q;
   assign flag_ht = ht_q;

   always_comb begin
      case (rd_idx)
         IDX_CTRL:  rd_data = 32'(ctrl_q);
         IDX_COUNT: rd_data = 32'(rem_q);
         IDX_SRC:   rd_data = 32'(csrc_q);
         IDX_DST:   rd_data = 32'(cdst_q);
         IDX_FLAGS: rd_data = {30'd0, ht_q, tc_q};
         default:   rd_data = '0;
      endcase
   end

   // R8
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= prog_q);

   // R8
   tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_q) |-> $past(item_done));

   // R10
   circ_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (item_done && ctrl_q.circ && rem_q == 1 && !cfg_wr) |=> (rem_q == prog_q && csrc_q == bsrc_q));

endmodule

// File: rtl/mc_dma_arb.sv
module mc_dma_arb #(
   parameter int NCH = 7,
   parameter int CHW = 3
) (
   input  logic [NCH-1:0]      elig,
   input  logic [NCH-1:0][1:0] prio,
   output logic                gnt_valid,
   output logic [CHW-1:0]      gnt_idx
);

   logic [1:0] best;

   // scan from the top index down with >=, so ties settle on the lowest index
   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      best      = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (elig[i] && (!gnt_valid || prio[i] >= best)) begin
            gnt_valid = 1'b1;
            gnt_idx   = CHW'(i);
            best      = prio[i];
         end
      end
   end

endmodule

// File: rtl/mc_dma_engine.sv
module mc_dma_engine
   import mc_dma_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int NCH = 7,
   parameter int CHW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           gnt_valid,
   input  logic [CHW-1:0] gnt_idx,
   input  logic [AW-1:0]  sel_src,
   input  logic [AW-1:0]  sel_dst,
   input  logic [1:0]     sel_ssz,
   input  logic [1:0]     sel_dsz,
   output logic           bus_req,
   output logic           bus_we,
   output logic [AW-1:0]  bus_addr,
   output logic [1:0]     bus_size,
   output logic [DW-1:0]  bus_wdata,
   input  logic [DW-1:0]  bus_rdata,
   input  logic           bus_ack,
   output logic           eng_idle,
   output logic [NCH-1:0] done_vec
);

   eng_state_e     st_q;
   logic [CHW-1:0] ch_q;
   logic [AW-1:0]  src_q, dst_q;
   logic [1:0]     ssz_q, dsz_q;
   logic [DW-1:0]  data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         ch_q   <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         ssz_q  <= '0;
         dsz_q  <= '0;
         data_q <= '0;
      end else begin
         case (st_q)
            ENG_IDLE: if (gnt_valid) begin
               ch_q  <= gnt_idx;
               src_q <= sel_src;
               dst_q <= sel_dst;
               ssz_q <= sel_ssz;
               dsz_q <= sel_dsz;
               st_q  <= ENG_RD;
            end
            ENG_RD: if (bus_ack) begin
               data_q <= bus_rdata & size_mask(ssz_q);
               st_q   <= ENG_WR;
            end
            ENG_WR: if (bus_ack) st_q <= ENG_IDLE;
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

   assign eng_idle  = (st_q == ENG_IDLE);
   assign bus_req   = (st_q != ENG_IDLE);
   assign bus_we    = (st_q == ENG_WR);
   assign bus_addr  = bus_we ? dst_q : src_q;
   assign bus_size  = bus_we ? dsz_q : ssz_q;
   assign bus_wdata = bus_we ? (data_q & size_mask(dsz_q)) : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_done
      assign done_vec[i] = (st_q == ENG_WR) && bus_ack && (ch_q == CHW'(i));
   end

   // R3
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R3
   done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_vec));

   // R5
   item_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_ack) |=> !bus_req);

endmodule

// File: rtl/mc_dma.sv
module mc_dma
   import mc_dma_pkg::*;
#(
   parameter int NCH = 7,
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int CW  = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0]         dreq,
   input  logic                   reg_wr,
   input  logic [$clog2(NCH)+2:0] reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   output logic                   bus_req,
   output logic                   bus_we,
   output logic [AW-1:0]          bus_addr,
   output logic [1:0]             bus_size,
   output logic [DW-1:0]          bus_wdata,
   input  logic [DW-1:0]          bus_rdata,
   input  logic                   bus_ack,
   output logic [NCH-1:0]         irq_tc,
   output logic [NCH-1:0]         irq_ht
);

   localparam int CHW = $clog2(NCH);

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("mc_dma: NCH must lie in 2..16");
   end
   if (DW != 32) begin : g_bad_dw
      $error("mc_dma: DW must be 32");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("mc_dma: AW must lie in 8..32");
   end
   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("mc_dma: CW must lie in 2..16");
   end

   logic [CHW-1:0]      reg_ch;
   logic [2:0]          reg_idx;
   chan_ctrl_t          ch_ctrl [NCH];
   logic [AW-1:0]       ch_src  [NCH];
   logic [AW-1:0]       ch_dst  [NCH];
   logic [31:0]         ch_rd   [NCH];
   logic [NCH-1:0]      ch_elig, done_vec;
   logic [NCH-1:0][1:0] ch_prio;
   logic                gnt_valid, eng_idle;
   logic [CHW-1:0]      gnt_idx;
   logic [AW-1:0]       sel_src, sel_dst;
   logic [1:0]          sel_ssz, sel_dsz;

   assign reg_ch  = reg_addr[CHW+2:3];
   assign reg_idx = reg_addr[2:0];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      mc_dma_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_wr    (reg_wr && (reg_ch == CHW'(i))),
         .cfg_idx   (reg_idx),
         .cfg_wdata (reg_wdata),
         .rd_idx    (reg_idx),
         .rd_data   (ch_rd[i]),
         .dreq      (dreq[i]),
         .item_done (done_vec[i]),
         .elig      (ch_elig[i]),
         .ctrl      (ch_ctrl[i]),
         .cur_src   (ch_src[i]),
         .cur_dst   (ch_dst[i]),
         .flag_tc   (irq_tc[i]),
         .flag_ht   (irq_ht[i])
      );
      assign ch_prio[i] = ch_ctrl[i].prio;
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (reg_ch == CHW'(i)) reg_rdata = ch_rd[i];
      end
   end

   mc_dma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
      .elig      (ch_elig),
      .prio      (ch_prio),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx)
   );

   always_comb begin
      sel_src = '0;
      sel_dst = '0;
      sel_ssz = '0;
      sel_dsz = '0;
      for (int i = 0; i < NCH; i++) begin
         if (gnt_idx == CHW'(i)) begin
            sel_src = ch_src[i];
            sel_dst = ch_dst[i];
            sel_ssz = ch_ctrl[i].ssz;
            sel_dsz = ch_ctrl[i].dsz;
         end
      end
   end

   mc_dma_engine #(.AW(AW), .DW(DW), .NCH(NCH), .CHW(CHW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt_valid (gnt_valid),
      .gnt_idx   (gnt_idx),
      .sel_src   (sel_src),
      .sel_dst   (sel_dst),
      .sel_ssz   (sel_ssz),
      .sel_dsz   (sel_dsz),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_ack   (bus_ack),
      .eng_idle  (eng_idle),
      .done_vec  (done_vec)
   );

   // R12
   grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> ch_elig[gnt_idx]);

   // R11
   start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_idle && !gnt_valid) |=> !bus_req);

endmodule

// File: tb/mc_dma_bench.sv
module mc_dma_bench;

   localparam int NCH = 7;

   logic        clk, rst_n;
   logic [NCH-1:0] dreq;
   logic        reg_wr;
   logic [5:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        bus_req, bus_we, bus_ack;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic [1:0]  bus_size;
   logic [NCH-1:0] irq_tc, irq_ht;

   mc_dma u_mc_dma (
      .clk(clk), .rst_n(rst_n), .dreq(dreq), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq_tc(irq_tc), .irq_ht(irq_ht)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int lg_n = 0;
   logic        lg_we   [1024];
   logic [31:0] lg_addr [1024];
   logic [31:0] lg_data [1024];
   logic [1:0]  lg_size [1024];
   logic [NCH-1:0] lg_ht [1024];
   int waitc = 0;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction
   function automatic logic [31:0] bmask(input logic [1:0] s);
      return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction
   function automatic int bstep(input logic [1:0] s);
      return (s == 0) ? 1 : (s == 1) ? 2 : 4;
   endfunction
   function automatic logic [31:0] mkctrl(input bit en, input bit circ, input bit si, input bit di,
                                          input logic [1:0] ss, input logic [1:0] ds, input logic [1:0] pr);
      return {22'd0, pr, ds, ss, di, si, circ, en};
   endfunction

   // bus slave model: random wait states, one-cycle ack, logs every beat
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack = 1'b0;
         waitc = 0;
      end else if (bus_ack) begin
         bus_ack = 1'b0;
      end else if (bus_req) begin
         if (waitc == 0) begin
            bus_ack = 1'b1;
            bus_rdata = bus_we ? 32'd0 : pat(bus_addr);
            if (lg_n < 1024) begin
               lg_we[lg_n] = bus_we; lg_addr[lg_n] = bus_addr;
               lg_data[lg_n] = bus_wdata; lg_size[lg_n] = bus_size; lg_ht[lg_n] = irq_ht;
               lg_n++;
            end
            waitc = $urandom_range(0, 2);
         end else begin
            waitc--;
         end
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL R3 watchdog expired actual=%0d expected<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int ch, input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = {ch[2:0], idx[2:0]}; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int ch, input int idx, output logic [31:0] d);
      @(negedge clk);
      reg_addr = {ch[2:0], idx[2:0]};
      #1 d = reg_rdata;
   endtask

   task automatic setup(input int ch, input int n, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] c);
      wr(ch, 1, n); wr(ch, 2, s); wr(ch, 3, d); wr(ch, 4, 3); wr(ch, 0, c);
   endtask

   task automatic wait_tc(input int ch);
      for (int c = 0; c < 2000 && !irq_tc[ch]; c++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic verify_run(input string tag, input int base, input int n, input logic [31:0] s0,
                             input logic [31:0] d0, input bit si, input bit di,
                             input logic [1:0] ss, input logic [1:0] ds);
      for (int k = 0; k < n; k++) begin
         logic [31:0] s, d, exp;
         bit ok;
         s = s0 + (si ? k * bstep(ss) : 0);
         d = d0 + (di ? k * bstep(ds) : 0);
         exp = pat(s) & bmask(ss) & bmask(ds);
         ok = !lg_we[base+2*k] && lg_addr[base+2*k] == s && lg_size[base+2*k] == ss &&
              lg_we[base+2*k+1] && lg_addr[base+2*k+1] == d && lg_size[base+2*k+1] == ds &&
              lg_data[base+2*k+1] == exp;
         chk(ok, tag, lg_data[base+2*k+1], exp);
      end
   endtask

   logic [31:0] v;

   initial begin
      void'($urandom(32'd24680));
      rst_n = 1'b0; dreq = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      bus_ack = 1'b0; bus_rdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 0);
      chk(irq_tc == '0 && irq_ht == '0, "R1 flags", 32'({irq_ht, irq_tc}), 0);
      rd(3, 0, v); chk(v == 0, "R1 ctrl read", v, 0);
      rd(5, 1, v); chk(v == 0, "R1 count read", v, 0);

      // R2 register readback, control masked to 10 bits
      wr(2, 0, 32'hFFFF_F2B6); rd(2, 0, v); chk(v == 32'h2B6, "R2 ctrl", v, 32'h2B6);
      wr(2, 1, 32'h1234);      rd(2, 1, v); chk(v == 32'h1234, "R2 count", v, 32'h1234);
      wr(2, 2, 32'hCAFE_0010); rd(2, 2, v); chk(v == 32'hCAFE_0010, "R2 src", v, 32'hCAFE_0010);
      wr(2, 3, 32'h0BAD_0020); rd(2, 3, v); chk(v == 32'h0BAD_0020, "R2 dst", v, 32'h0BAD_0020);
      wr(2, 0, 0); wr(2, 1, 0);

      // R3 R6 R8 plain word run
      lg_n = 0;
      setup(0, 4, 32'h100, 32'h200, mkctrl(1, 0, 1, 1, 2, 2, 0));
      dreq[0] = 1'b1; wait_tc(0); dreq[0] = 1'b0;
      chk(lg_n == 8, "R3 beat count", lg_n, 8);
      verify_run("R3 word item", 0, 4, 32'h100, 32'h200, 1, 1, 2, 2);
      rd(0, 2, v); chk(v == 32'h110, "R6 src advanced", v, 32'h110);
      rd(0, 3, v); chk(v == 32'h210, "R6 dst advanced", v, 32'h210);
      rd(0, 1, v); chk(v == 0, "R8 remaining zero", v, 0);
      rd(0, 4, v); chk(v == 3, "R8 flags set", v, 3);
      wr(0, 0, 0);

      // R6 R7 byte source into non-incrementing word destination
      lg_n = 0;
      setup(1, 3, 32'h501, 32'h900, mkctrl(1, 0, 1, 0, 0, 2, 1));
      dreq[1] = 1'b1; wait_tc(1); dreq[1] = 1'b0;
      verify_run("R7 byte widened", 0, 3, 32'h501, 32'h900, 1, 0, 0, 2);
      rd(1, 3, v); chk(v == 32'h900, "R6 dst held", v, 32'h900);
      wr(1, 0, 0);

      // R9 half flag on odd count 5: rises after third item
      lg_n = 0;
      setup(2, 5, 32'hA00, 32'hB00, mkctrl(1, 0, 1, 1, 2, 2, 0));
      dreq[2] = 1'b1; wait_tc(2); dreq[2] = 1'b0;
      chk(lg_ht[5][2] == 1'b0, "R9 half not after 2 items", 32'(lg_ht[5][2]), 0);
      chk(lg_ht[7][2] == 1'b1, "R9 half after 3 items", 32'(lg_ht[7][2]), 1);
      wr(2, 0, 0);

      // R4 priority order: ch1 p2, ch3 p1, ch5 p2 raised together
      lg_n = 0;
      setup(1, 2, 32'h10, 32'h1000, mkctrl(1, 0, 1, 1, 2, 2, 2));
      setup(3, 2, 32'h30, 32'h3000, mkctrl(1, 0, 1, 1, 2, 2, 1));
      setup(5, 2, 32'h50, 32'h5000, mkctrl(1, 0, 1, 1, 2, 2, 2));
      @(negedge clk); dreq = 7'b0101010;
      wait_tc(3); wait_tc(1); wait_tc(5); dreq = '0;
      begin
         logic [31:0] order [6];
         order = '{32'h1000, 32'h1004, 32'h5000, 32'h5004, 32'h3000, 32'h3004};
         for (int k = 0; k < 6; k++)
            chk(lg_addr[2*k+1] == order[k], "R4 service order", lg_addr[2*k+1], order[k]);
      end
      wr(1, 0, 0); wr(3, 0, 0); wr(5, 0, 0);

      // R5 preemption between items
      lg_n = 0;
      setup(4, 2, 32'h70, 32'h7000, mkctrl(1, 0, 1, 1, 2, 2, 3));
      setup(0, 6, 32'h60, 32'h6000, mkctrl(1, 0, 1, 1, 2, 2, 0));
      dreq[0] = 1'b1;
      for (int c = 0; c < 500 && lg_n < 4; c++) @(negedge clk);
      dreq[4] = 1'b1;
      wait_tc(4); wait_tc(0); dreq = '0;
      begin
         int first4, last4, n0after;
         first4 = -1; last4 = -1; n0after = 0;
         for (int k = 0; k < lg_n / 2; k++) begin
            if (lg_addr[2*k+1][15:12] == 4'h7) begin
               if (first4 < 0) first4 = k;
               last4 = k;
            end else if (last4 >= 0) n0after++;
         end
         chk(lg_n == 16, "R5 total beats", lg_n, 16);
         chk(last4 == first4 + 1, "R5 high items adjacent", last4, first4 + 1);
         chk(n0after >= 1, "R5 low run resumes after", n0after, 1);
      end
      wr(0, 0, 0); wr(4, 0, 0);

      // R12 request low or zero count
      lg_n = 0;
      setup(6, 0, 32'h0, 32'h0, mkctrl(1, 0, 1, 1, 2, 2, 3));
      setup(2, 3, 32'h0, 32'h0, mkctrl(1, 0, 1, 1, 2, 2, 3));
      dreq[6] = 1'b1;
      repeat (40) @(negedge clk);
      chk(lg_n == 0 && bus_req == 1'b0, "R12 no service", lg_n, 0);
      rd(2, 1, v); chk(v == 3, "R12 count untouched", v, 3);
      dreq = '0; wr(6, 0, 0); wr(2, 0, 0);

      // R10 R11 circular run stopped by clearing enable
      lg_n = 0;
      setup(0, 2, 32'h300, 32'h400, mkctrl(1, 1, 1, 1, 2, 2, 0));
      dreq[0] = 1'b1;
      for (int c = 0; c < 1000 && lg_n < 10; c++) @(negedge clk);
      wr(0, 0, mkctrl(0, 1, 1, 1, 2, 2, 0));
      repeat (30) @(negedge clk);
      begin
         int items, snap;
         items = lg_n / 2;
         chk(lg_n % 2 == 0 && items >= 5 && items <= 7, "R11 stop after in-flight", items, 6);
         verify_run("R10 wrap item 0", 0, 2, 32'h300, 32'h400, 1, 1, 2, 2);
         for (int k = 2; k < items; k++)
            chk(lg_addr[2*k+1] == 32'h400 + 4 * (k % 2), "R10 wrap address",
                lg_addr[2*k+1], 32'h400 + 4 * (k % 2));
         snap = lg_n;
         repeat (20) @(negedge clk);
         chk(lg_n == snap && bus_req == 1'b0, "R11 no further item", lg_n, snap);
      end
      dreq[0] = 1'b0;
      rd(0, 4, v); chk(v == 3, "R11 flags persist", v, 3);
      wr(0, 4, 1); rd(0, 4, v); chk(v == 2, "R11 clear complete only", v, 2);
      wr(0, 4, 2); rd(0, 4, v); chk(v == 0, "R11 clear half", v, 0);

      // R6 R7 random setups
      for (int it = 0; it < 10; it++) begin
         int ch, n;
         logic [1:0] ss, ds;
         bit si, di;
         logic [31:0] s0, d0;
         ch = $urandom_range(0, 6); n = $urandom_range(1, 6);
         ss = 2'($urandom_range(0, 2)); ds = 2'($urandom_range(0, 2));
         si = 1'($urandom_range(0, 1)); di = 1'($urandom_range(0, 1));
         s0 = 32'h8000 + ($urandom_range(0, 63) << 4);
         d0 = 32'hC000 + ($urandom_range(0, 63) << 4);
         lg_n = 0;
         setup(ch, n, s0, d0, mkctrl(1, 0, si, di, ss, ds, 2'($urandom_range(0, 3))));
         dreq[ch] = 1'b1; wait_tc(ch); dreq[ch] = 1'b0;
         chk(lg_n == 2 * n, "R8 random beat count", lg_n, 2 * n);
         verify_run("R7 random item", 0, n, s0, d0, si, di, ss, ds);
         wr(ch, 0, 0); wr(ch, 4, 3);
      end

      summary();
      $finish;
   end

endmodule